// File: doc/BRIEF.md
# Cache Array Access Port

This block lets software reach straight into the storage of a four-way set-associative write-back cache with 16-byte lines. It uses ordinary load and store cycles on a simple CPU-side bus. The top byte of the 32-bit address chooses the region. One region holds the tag array, with a tag, a valid bit and a dirty bit per way plus a shared LRU field per entry. The other region holds the data array, with four longwords per line per way. Requests to any other region are accepted and have no effect.

A store to the tag region with the associative flag set is the main use. It searches every way of the addressed entry for a valid line whose tag matches the tag in the store data. Only the first matching way has its valid and dirty bits rewritten. Its tag and the entry's LRU field stay as they were. When the matching line was dirty, the block raises a one-cycle dirty-hit flag so that a separate engine can write the line back. A store without the flag writes one way directly, and loads read fields or longwords back. Software uses this to invalidate single lines and to inspect or patch cache contents.

Top module: `cap_port`

## Requirements
- R1: After reset, every valid bit, dirty bit and LRU field reads as zero. `req_ready` is 1, and `rsp_valid` and `dirty_hit` are 0.
- R2: Address byte 31:24 equal to 0xF0 selects the tag region, and 0xF1 selects the data region. Entry = bits 11:4, way = bits 13:12, longword = bits 3:2 (data region only), associative flag = bit 3 (tag region only), and bits 1:0 are ignored. A store to any other region changes nothing, and a load there returns 0.
- R3: A data-region store writes one 32-bit longword. A data-region load returns that longword with `rsp_valid` high in the cycle after acceptance. `rsp_valid` is low after stores.
- R4: Data-region loads and stores leave every tag, valid, dirty and LRU value unchanged.
- R5: A tag-region store with bit 3 clear writes, at the addressed entry and way: tag = data 31:10, LRU = data 9:4, dirty = data 1 and valid = data 0. A tag-region load returns that word one cycle later, with bits 3:2 reading 0.
- R6: A tag-region store with bit 3 set compares data 31:10 with the tag of every valid way at the entry. A way counts as a hit only when its stored valid bit is 1. The lowest-numbered hitting way gets the new valid and dirty bits, and its tag and the entry's LRU field stay unchanged.
- R7: An associative store with no hitting way modifies nothing.
- R8: Whenever the written valid bit is 0, the stored dirty bit becomes 0. This holds for both direct and associative stores.
- R9: `dirty_hit` is 1 for exactly the cycle after acceptance of an associative store whose hitting way had dirty = 1. It is 0 in every other cycle.
- R10: An associative store occupies two cycles. `req_ready` is 0 in the cycle after its acceptance and returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| dirty_hit | output | 1 | Associative store hit a dirty line |

## Verification
The two functions that can fall in the same cycle are the compare of an associative store and the result of the request before it. One case is a load response returned while the next request is being taken. The other is the dirty-hit pulse, which occurs in the same cycle as the stall that holds `req_ready` low. The bench sends associative stores directly after loads, and in that cycle it samples `dirty_hit` and `req_ready` together. It then reads the tag words back to confirm that only the valid and dirty bits of the single selected way moved, and that the LRU field kept its value.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_TAG, SRC_DATA} rsp_src_e;

  // an invalid line is never left dirty
  function automatic logic clean_dirty(input logic v, input logic u);
    return v & u;
  endfunction

  function automatic logic [7:0] region_of(input logic [31:0] a);
    return a[31:24];
  endfunction
endpackage

// File: rtl/cap_decode.sv
module cap_decode #(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS   = 2,
  parameter logic [7:0] TAG_REGION  = 8'hF0,
  parameter logic [7:0] DATA_REGION = 8'hF1
) (
  input  logic [31:0]           addr,
  output logic                  is_tag,
  output logic                  is_data,
  output logic                  assoc,
  output logic [ENTRY_BITS-1:0] entry,
  output logic [WAY_BITS-1:0]   way,
  output logic [1:0]            word
);
  import cap_pkg::*;
  localparam int WAY_LSB = 4 + ENTRY_BITS;

  assign is_tag  = region_of(addr) == TAG_REGION;
  assign is_data = region_of(addr) == DATA_REGION;
  assign assoc   = addr[3];
  assign word    = addr[3:2];
  assign entry   = addr[4 +: ENTRY_BITS];
  assign way     = addr[WAY_LSB +: WAY_BITS];

  logic unused_addr;
  assign unused_addr = ^addr;
endmodule

// File: rtl/cap_data_array.sv
module cap_data_array #(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS   = 2,
  parameter int DW         = 32
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic                  re,
  input  logic [ENTRY_BITS-1:0] entry,
  input  logic [WAY_BITS-1:0]   way,
  input  logic [1:0]            word,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata
);
  localparam int NW    = 1 << WAY_BITS;
  localparam int DEPTH = 1 << (ENTRY_BITS + 2);

  logic [NW*DW-1:0]   rd_flat;
  logic [WAY_BITS-1:0] way_q;

  for (genvar g = 0; g < NW; g++) begin : g_way
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && way == WAY_BITS'(g)) mem[{entry, word}] <= wdata;
      if (re && way == WAY_BITS'(g)) rd_q <= mem[{entry, word}];
    end
    assign rd_flat[g*DW +: DW] = rd_q;
  end

  always_ff @(posedge clk) if (re) way_q <= way;

  assign rdata = rd_flat[way_q*DW +: DW];
endmodule

// File: rtl/cap_tag_array.sv
module cap_tag_array #(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS   = 2,
  parameter int TAG_W      = 22,
  parameter int LRU_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic                  assoc_en,
  input  logic [ENTRY_BITS-1:0] entry,
  input  logic [WAY_BITS-1:0]   way,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  busy,
  output logic                  dirty_hit
);
  import cap_pkg::*;
  localparam int NW = 1 << WAY_BITS;
  localparam int NE = 1 << ENTRY_BITS;

  logic [TAG_W-1:0] tag_q [NE][NW];
  logic [NW-1:0]    v_q   [NE];
  logic [NW-1:0]    u_q   [NE];
  logic [LRU_W-1:0] lru_q [NE];

  logic [TAG_W-1:0] in_tag;
  logic [LRU_W-1:0] in_lru;
  assign in_tag = wdata[31 -: TAG_W];
  assign in_lru = wdata[4 +: LRU_W];

  // compare stage (first cycle)
  logic [NW-1:0]       hit_vec;
  logic                any_hit;
  logic [WAY_BITS-1:0] hit_way;
  for (genvar g = 0; g < NW; g++) begin : g_cmp
    assign hit_vec[g] = v_q[entry][g] && (tag_q[entry][g] == in_tag);
  end
  assign any_hit = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = NW - 1; w >= 0; w--) if (hit_vec[w]) hit_way = WAY_BITS'(w);
  end

  // update stage (second cycle)
  logic                  s2_valid, s2_hit, s2_v, s2_u;
  logic [WAY_BITS-1:0]   s2_way;
  logic [ENTRY_BITS-1:0] s2_entry;
  logic                  upd_en;
  assign upd_en = s2_valid && s2_hit;
  assign busy   = s2_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_hit    <= 1'b0;
      dirty_hit <= 1'b0;
      rdata     <= '0;
      for (int e = 0; e < NE; e++) begin
        v_q[e]   <= '0;
        u_q[e]   <= '0;
        lru_q[e] <= '0;
      end
    end else begin
      s2_valid  <= assoc_en;
      dirty_hit <= assoc_en && any_hit && u_q[entry][hit_way];
      if (assoc_en) begin
        s2_hit   <= any_hit;
        s2_way   <= hit_way;
        s2_entry <= entry;
        s2_v     <= wdata[0];
        s2_u     <= clean_dirty(wdata[0], wdata[1]);
      end
      if (upd_en) begin
        v_q[s2_entry][s2_way] <= s2_v;
        u_q[s2_entry][s2_way] <= s2_u;
      end
      if (wr_en) begin
        v_q[entry][way] <= wdata[0];
        u_q[entry][way] <= clean_dirty(wdata[0], wdata[1]);
        lru_q[entry]    <= in_lru;
      end
      if (rd_en)
        rdata <= {tag_q[entry][way], lru_q[entry], 2'b00, u_q[entry][way], v_q[entry][way]};
    end
  end

  always_ff @(posedge clk) if (wr_en) tag_q[entry][way] <= in_tag;

  logic unused_wdata;
  assign unused_wdata = ^wdata[3:2];

  // R9: the dirty flag only follows an accepted associative store
  a_r9_dirty_after_assoc: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_hit |-> $past(assoc_en));
  // R6: the LRU field of the updated entry survives the update
  a_r6_lru_kept: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> lru_q[$past(s2_entry)] == $past(lru_q[s2_entry]));
  // R8: the way just updated is never invalid and dirty
  a_r8_clean_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (v_q[$past(s2_entry)][$past(s2_way)] || !u_q[$past(s2_entry)][$past(s2_way)]));
  // R7: a missing compare leaves the entry's valid bits alone
  a_r7_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_hit) |=> $stable(v_q[$past(s2_entry)]));
endmodule

// File: rtl/cap_port.sv
module cap_port #(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS   = 2,
  parameter int TAG_W      = 22,
  parameter int LRU_W      = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        dirty_hit
);
  import cap_pkg::*;

  logic                  is_tag, is_data, assoc;
  logic [ENTRY_BITS-1:0] entry;
  logic [WAY_BITS-1:0]   way;
  logic [1:0]            word;

  cap_decode #(.ENTRY_BITS(ENTRY_BITS), .WAY_BITS(WAY_BITS)) u_dec (
    .addr(req_addr), .is_tag(is_tag), .is_data(is_data), .assoc(assoc),
    .entry(entry), .way(way), .word(word));

  logic accept, rd_accept, tag_rd, tag_wr, tag_assoc, data_rd, data_wr, busy;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign rd_accept = accept && !req_write;
  assign tag_rd    = rd_accept && is_tag;
  assign tag_wr    = accept && req_write && is_tag && !assoc;
  assign tag_assoc = accept && req_write && is_tag && assoc;
  assign data_rd   = rd_accept && is_data;
  assign data_wr   = accept && req_write && is_data;

  logic [31:0] tag_rdata, data_rdata;

  cap_tag_array #(.ENTRY_BITS(ENTRY_BITS), .WAY_BITS(WAY_BITS),
                  .TAG_W(TAG_W), .LRU_W(LRU_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .rd_en(tag_rd), .wr_en(tag_wr), .assoc_en(tag_assoc),
    .entry(entry), .way(way), .wdata(req_wdata), .rdata(tag_rdata),
    .busy(busy), .dirty_hit(dirty_hit));

  cap_data_array #(.ENTRY_BITS(ENTRY_BITS), .WAY_BITS(WAY_BITS), .DW(32)) u_data (
    .clk(clk), .we(data_wr), .re(data_rd), .entry(entry), .way(way), .word(word),
    .wdata(req_wdata), .rdata(data_rdata));

  rsp_src_e src_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_NONE;
    end else begin
      rsp_valid <= rd_accept;
      if (rd_accept) src_q <= is_tag ? SRC_TAG : (is_data ? SRC_DATA : SRC_NONE);
    end
  end

  always_comb begin
    case (src_q)
      SRC_TAG:  rsp_rdata = tag_rdata;
      SRC_DATA: rsp_rdata = data_rdata;
      default:  rsp_rdata = '0;
    endcase
  end

  // R3: a response only follows an accepted load
  a_r3_rsp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_accept));
  // R10: the stall lasts one cycle
  a_r10_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  // R10: an accepted associative store stalls the next cycle
  a_r10_assoc_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    tag_assoc |=> !req_ready);
endmodule

// File: tb/cap_port_tb.sv
module cap_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, dirty_hit;
  logic [31:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_port u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dirty_hit(dirty_hit));

  int total = 0, bad = 0;
  bit finished = 0;

  // kind: 0 store (no response expected), 1 load (check data), 2 associative (check dirty_hit)
  typedef struct packed {
    logic        wr;
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  kind;
    logic [31:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{1'b1, 32'hF0000050, 32'h0048D2A3, 2'd0, 32'h0, 4'd5},  // R5 way0 tag 0x1234 dirty
    '{1'b1, 32'hF0002050, 32'h001DDEA1, 2'd0, 32'h0, 4'd5},  // R5 way2 tag 0x777 clean
    '{1'b0, 32'hF0000050, 32'h0,        2'd1, 32'h0048D2A3, 4'd5},  // R5
    '{1'b0, 32'hF0002050, 32'h0,        2'd1, 32'h001DDEA1, 4'd5},  // R5
    '{1'b1, 32'hF0001050, 32'h000156A2, 2'd0, 32'h0, 4'd8},  // R8 invalid+dirty written
    '{1'b0, 32'hF0001050, 32'h0,        2'd1, 32'h000156A0, 4'd8},  // R8 dirty forced 0
    '{1'b1, 32'hF1000054, 32'hDEADBEEF, 2'd0, 32'h0, 4'd3},  // R3
    '{1'b1, 32'hF1003058, 32'h0BADF00D, 2'd0, 32'h0, 4'd3},  // R3 way3 word2
    '{1'b1, 32'hF1002053, 32'h13579BDF, 2'd0, 32'h0, 4'd2},  // R2 low bits ignored
    '{1'b0, 32'hF1000054, 32'h0,        2'd1, 32'hDEADBEEF, 4'd3},  // R3
    '{1'b0, 32'hF1003058, 32'h0,        2'd1, 32'h0BADF00D, 4'd3},  // R3
    '{1'b0, 32'hF1002050, 32'h0,        2'd1, 32'h13579BDF, 4'd2},  // R2
    '{1'b0, 32'hF0000050, 32'h0,        2'd1, 32'h0048D2A3, 4'd4},  // R4 tag untouched
    '{1'b1, 32'hF0000058, 32'h0048D001, 2'd2, 32'h1, 4'd9},  // R9 dirty hit way0
    '{1'b0, 32'hF0000050, 32'h0,        2'd1, 32'h0048D2A1, 4'd6},  // R6 tag+LRU kept
    '{1'b1, 32'hF0000058, 32'h0048D001, 2'd2, 32'h0, 4'd9},  // R9 clean hit
    '{1'b1, 32'hF0000058, 32'h0048D403, 2'd2, 32'h0, 4'd7},  // R7 miss
    '{1'b0, 32'hF0000050, 32'h0,        2'd1, 32'h0048D2A1, 4'd7},  // R7
    '{1'b1, 32'hF0000058, 32'h00015403, 2'd2, 32'h0, 4'd6},  // R6 invalid way no hit
    '{1'b0, 32'hF0001050, 32'h0,        2'd1, 32'h000156A0, 4'd6},  // R6
    '{1'b1, 32'hF0000058, 32'h001DDC02, 2'd2, 32'h0, 4'd8},  // R8 invalidate way2
    '{1'b0, 32'hF0002050, 32'h0,        2'd1, 32'h001DDEA0, 4'd8},  // R8
    '{1'b1, 32'h12345678, 32'hFFFFFFFF, 2'd0, 32'h0, 4'd2},  // R2 other region
    '{1'b0, 32'h12345678, 32'h0,        2'd1, 32'h0, 4'd2},  // R2 reads zero
    '{1'b0, 32'hF1000054, 32'h0,        2'd1, 32'hDEADBEEF, 4'd4}   // R4 data kept
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns outputs sampled at the next falling edge
  task automatic op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                    output logic [31:0] rd, output logic rv, output logic dh);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; rv = rsp_valid; dh = dirty_hit;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic rv, dh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
    check(rsp_valid === 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check(dirty_hit === 1'b0, "R1 dirty_hit", {31'b0, dirty_hit}, 32'h0);
    op(1'b0, 32'hF0003000, 32'h0, rd, rv, dh);
    check(rv === 1'b1 && rd[9:0] === 10'h0, "R1 tag word after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VT[i].wr, VT[i].a, VT[i].d, rd, rv, dh);
      if (VT[i].kind == 2'd1)
        check(rv === 1'b1 && rd === VT[i].e, $sformatf("R%0d vec %0d", VT[i].rq, i), rd, VT[i].e);
      else if (VT[i].kind == 2'd2)
        check(dh === VT[i].e[0], $sformatf("R%0d vec %0d dirty_hit", VT[i].rq, i), {31'b0, dh}, VT[i].e);
      else
        check(rv === 1'b0, $sformatf("R%0d vec %0d no response", VT[i].rq, i), {31'b0, rv}, 32'h0);
    end

    // R6 priority: two ways with the same tag, the lower one updates
    op(1'b1, 32'hF0001090, 32'h00010803, rd, rv, dh);
    op(1'b1, 32'hF0003090, 32'h00010803, rd, rv, dh);
    op(1'b1, 32'hF0000098, 32'h00010801, rd, rv, dh);
    check(dh === 1'b1, "R9 dirty hit on duplicate", {31'b0, dh}, 32'h1);
    // R10 stall visible in the same cycle as the dirty flag
    check(req_ready === 1'b0, "R10 stall cycle", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    check(req_ready === 1'b1, "R10 ready again", {31'b0, req_ready}, 32'h1);
    check(dirty_hit === 1'b0, "R9 single cycle pulse", {31'b0, dirty_hit}, 32'h0);
    op(1'b0, 32'hF0001090, 32'h0, rd, rv, dh);
    check(rd === 32'h00010801, "R6 lowest way updated", rd, 32'h00010801);
    op(1'b0, 32'hF0003090, 32'h0, rd, rv, dh);
    check(rd === 32'h00010803, "R6 higher way kept", rd, 32'h00010803);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule